// File: doc/BRIEF.md
# Predicated Operand Translation Table

This block sits between register renaming and operand read in an out-of-order core that runs predicated instructions. Each table entry is an indirection record. It tells a reader where the current value of a renamed destination lives: in a physical register, in the committed logical register file, or nowhere yet. The block keeps a small pool of physical register numbers. It grants one of these numbers when a result is written back, and it takes the number back when that result is committed.

Rename claims an entry for every destination. Write-back reports whether the producing instruction was kept or was cancelled by a false predicate. A cancelled write is resolved by redirecting the entry to the previous translation. This happens at write-back if the previous entry is ready: a value copy when that value sits in a physical register, and a plain mark when it sits in the logical file. If the previous entry is not ready, the redirection waits for commit. The commit step moves a physical value into the logical file and releases the previous entry. A combinational read port turns an entry number plus a logical register number into a ready flag, a file select and an address.

Each entry is a four-state machine:
- FREE: not valid.
- WAIT: valid, not ready.
- PHYS: ready, translated to a physical register.
- LOG: ready, read from the logical file.

The transitions are:
- FREE→WAIT on allocation.
- WAIT→PHYS on a granted write-back (kept or copy).
- WAIT→LOG on a cancelled write-back whose old entry is LOG, or on commit.
- PHYS→LOG on commit.
- any→FREE when released as the old entry of a commit.

Write-back picks one action per cycle:
- IDLE: nothing to do.
- TAKE: a kept result gets a physical register.
- COPY: a cancelled result copies the old physical value.
- LOG: a cancelled result is redirected to the logical file.
- HOLD: the pool is empty, so write-back stalls.

In any one cycle, allocation, write-back and commit address distinct entries.

Top module: `xrt_table`

## Requirements
- R1: After reset, entries 0 to NUM_LOG-1 are valid, ready and untranslated (state LOG). The other entries are FREE, and every physical register is free.
- R2: Allocating a FREE entry makes it valid with the ready and translation flags clear (WAIT).
- R3: A kept write-back to a WAIT entry is granted the lowest-numbered free physical register (wb_phys_valid=1, wb_phys_prn). The entry then reads ready and translated to that number.
- R4: When a write-back needs a physical register and the pool is empty, wb_stall=1 and nothing is granted. The entry keeps its state.
- R5: A cancelled write-back whose old entry is in PHYS copy-allocates. It grants a fresh register and raises wb_copy with wb_copy_src equal to the old entry's physical number. The entry becomes ready and translated.
- R6: A cancelled write-back whose old entry is in LOG makes the entry ready and untranslated without using a physical register.
- R7: A cancelled write-back whose old entry is not ready (WAIT or FREE) changes nothing and raises no output. A later commit marks the entry ready and untranslated.
- R8: Committing a translated entry raises cm_move_valid with its physical number and clears the translation. The number returns to the pool, where it can be granted from the next cycle.
- R9: A commit releases cm_old_idx: that entry becomes FREE and reads not ready.
- R10: The read port reports rd_ready=1 only for PHYS or LOG. rd_phys=1 selects the physical file at the stored number. Otherwise rd_addr equals rd_lreg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Rename claims an entry |
| alloc_idx | input | EW | Entry being claimed |
| wb_valid | input | 1 | Write-back event |
| wb_idx | input | EW | Entry of the written destination |
| wb_cancel | input | 1 | Instruction cancelled by its predicate |
| wb_old_idx | input | EW | Previous entry of the same logical register |
| wb_stall | output | 1 | Write-back must retry: pool empty |
| wb_phys_valid | output | 1 | A physical register was granted |
| wb_phys_prn | output | PW | Granted physical register |
| wb_copy | output | 1 | Copy wb_copy_src into wb_phys_prn |
| wb_copy_src | output | PW | Source physical register of the copy |
| cm_valid | input | 1 | Commit event |
| cm_idx | input | EW | Entry being committed |
| cm_old_idx | input | EW | Previous entry to release |
| cm_move_valid | output | 1 | Move physical value to logical file |
| cm_move_prn | output | PW | Physical register being retired |
| rd_idx | input | EW | Entry to translate |
| rd_lreg | input | LW | Logical register of the operand |
| rd_ready | output | 1 | Operand available |
| rd_phys | output | 1 | 1: physical file, 0: logical file |
| rd_addr | output | AW | Index into the selected file |

## Verification
Some rules are checked by assertions on every cycle. The pool count plus the number of translated entries always equals the pool size. Every grant comes from a free register. A stall leaves the entry frozen. A commit leaves its entry LOG and its old entry FREE. A retired register is free one cycle later. Only the bench's long seeded operation sequence, checked against a bench model, can show the rest: the lowest-first grant order, the exact copy source, the read address in every state, and the delayed resolution of a cancelled write behind a not-ready entry.

// File: rtl/xrt_pkg.sv
package xrt_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_PHYS = 2'd2,
        SLOT_LOG  = 2'd3
    } slot_state_e;

    typedef enum logic [2:0] {
        WB_IDLE = 3'd0,
        WB_TAKE = 3'd1,
        WB_COPY = 3'd2,
        WB_LOG  = 3'd3,
        WB_HOLD = 3'd4
    } wb_act_e;
endpackage

// File: rtl/xrt_phys_pool.sv
module xrt_phys_pool #(
    parameter int NUM_PHYS = 8,
    parameter int PW       = $clog2(NUM_PHYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic                give,
    input  logic [PW-1:0]       give_prn,
    output logic                empty,
    output logic [PW-1:0]       grant_prn,
    output logic [NUM_PHYS-1:0] free_map
);
    // lowest free register wins
    always_comb begin
        grant_prn = '0;
        for (int i = NUM_PHYS - 1; i >= 0; i--) begin
            if (free_map[i]) grant_prn = PW'(i);
        end
    end

    assign empty = ~|free_map;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_map <= '1;
        end else begin
            if (give) free_map[give_prn] <= 1'b1;
            if (take && !empty) free_map[grant_prn] <= 1'b0;
        end
    end
endmodule

// File: rtl/xrt_slot.sv
module xrt_slot
    import xrt_pkg::*;
#(
    parameter int PW    = 3,
    parameter bit OWNED = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_alloc,
    input  logic        ev_release,
    input  logic        ev_wb_phys,
    input  logic        ev_wb_log,
    input  logic        ev_commit,
    input  logic [PW-1:0] wb_prn,
    output slot_state_e state_o,
    output logic [PW-1:0] prn_o
);
    slot_state_e   state_q, state_d;
    logic [PW-1:0] prn_q, prn_d;

    always_comb begin
        state_d = state_q;
        prn_d   = prn_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (ev_alloc) state_d = SLOT_WAIT;
            end
            SLOT_WAIT: begin
                if (ev_wb_phys) begin
                    state_d = SLOT_PHYS;
                    prn_d   = wb_prn;
                end else if (ev_wb_log || ev_commit) begin
                    state_d = SLOT_LOG;
                end
            end
            SLOT_PHYS: begin
                if (ev_commit) state_d = SLOT_LOG;
            end
            SLOT_LOG: begin
                state_d = SLOT_LOG;
            end
            default: state_d = SLOT_FREE;
        endcase
        if (ev_release) state_d = SLOT_FREE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OWNED ? SLOT_LOG : SLOT_FREE;
            prn_q   <= '0;
        end else begin
            state_q <= state_d;
            prn_q   <= prn_d;
        end
    end

    assign state_o = state_q;
    assign prn_o   = prn_q;
endmodule

// File: rtl/xrt_table.sv
module xrt_table
    import xrt_pkg::*;
#(
    parameter int NUM_LOG  = 8,
    parameter int NUM_ENT  = 16,
    parameter int NUM_PHYS = 8,
    localparam int EW = $clog2(NUM_ENT),
    localparam int LW = $clog2(NUM_LOG),
    localparam int PW = $clog2(NUM_PHYS),
    localparam int AW = (LW > PW) ? LW : PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic [EW-1:0] alloc_idx,
    input  logic          wb_valid,
    input  logic [EW-1:0] wb_idx,
    input  logic          wb_cancel,
    input  logic [EW-1:0] wb_old_idx,
    output logic          wb_stall,
    output logic          wb_phys_valid,
    output logic [PW-1:0] wb_phys_prn,
    output logic          wb_copy,
    output logic [PW-1:0] wb_copy_src,
    input  logic          cm_valid,
    input  logic [EW-1:0] cm_idx,
    input  logic [EW-1:0] cm_old_idx,
    output logic          cm_move_valid,
    output logic [PW-1:0] cm_move_prn,
    input  logic [EW-1:0] rd_idx,
    input  logic [LW-1:0] rd_lreg,
    output logic          rd_ready,
    output logic          rd_phys,
    output logic [AW-1:0] rd_addr
);
    slot_state_e [NUM_ENT-1:0]          st;
    logic        [NUM_ENT-1:0][PW-1:0] prn_q;
    logic        [NUM_PHYS-1:0]        free_map;
    logic                              pool_empty;
    logic        [PW-1:0]              pool_grant;
    logic                              pool_take;
    wb_act_e                           wb_act;

    // write-back action selection
    always_comb begin
        wb_act = WB_IDLE;
        if (wb_valid && st[wb_idx] == SLOT_WAIT) begin
            if (!wb_cancel) begin
                wb_act = pool_empty ? WB_HOLD : WB_TAKE;
            end else begin
                unique case (st[wb_old_idx])
                    SLOT_PHYS: wb_act = pool_empty ? WB_HOLD : WB_COPY;
                    SLOT_LOG:  wb_act = WB_LOG;
                    default:   wb_act = WB_IDLE;
                endcase
            end
        end
    end

    // write-back outputs
    always_comb begin
        wb_stall      = 1'b0;
        wb_phys_valid = 1'b0;
        wb_phys_prn   = '0;
        wb_copy       = 1'b0;
        wb_copy_src   = '0;
        unique case (wb_act)
            WB_TAKE: begin
                wb_phys_valid = 1'b1;
                wb_phys_prn   = pool_grant;
            end
            WB_COPY: begin
                wb_phys_valid = 1'b1;
                wb_phys_prn   = pool_grant;
                wb_copy       = 1'b1;
                wb_copy_src   = prn_q[wb_old_idx];
            end
            WB_HOLD: wb_stall = 1'b1;
            default: wb_stall = 1'b0;
        endcase
    end

    assign pool_take     = wb_phys_valid;
    assign cm_move_valid = cm_valid && st[cm_idx] == SLOT_PHYS;
    assign cm_move_prn   = prn_q[cm_idx];

    xrt_phys_pool #(.NUM_PHYS(NUM_PHYS), .PW(PW)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (pool_take),
        .give     (cm_move_valid),
        .give_prn (cm_move_prn),
        .empty    (pool_empty),
        .grant_prn(pool_grant),
        .free_map (free_map)
    );

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_slot
        xrt_slot #(.PW(PW), .OWNED(i < NUM_LOG)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev_alloc  (alloc_valid && alloc_idx == EW'(i)),
            .ev_release(cm_valid && cm_old_idx == EW'(i)),
            .ev_wb_phys(pool_take && wb_idx == EW'(i)),
            .ev_wb_log (wb_act == WB_LOG && wb_idx == EW'(i)),
            .ev_commit (cm_valid && cm_idx == EW'(i)),
            .wb_prn    (pool_grant),
            .state_o   (st[i]),
            .prn_o     (prn_q[i])
        );
    end

    // read translation
    always_comb begin
        rd_ready = 1'b0;
        rd_phys  = 1'b0;
        unique case (st[rd_idx])
            SLOT_PHYS: begin
                rd_ready = 1'b1;
                rd_phys  = 1'b1;
            end
            SLOT_LOG: rd_ready = 1'b1;
            default:  rd_ready = 1'b0;
        endcase
        rd_addr = rd_phys ? AW'(prn_q[rd_idx]) : AW'(rd_lreg);
    end
endmodule

// File: rtl/xrt_checker.sv
module xrt_checker #(
    parameter int NUM_ENT  = 16,
    parameter int NUM_PHYS = 8,
    localparam int EW = $clog2(NUM_ENT),
    localparam int PW = $clog2(NUM_PHYS)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_ENT-1:0][1:0]    st,
    input logic [NUM_ENT-1:0][PW-1:0] prn_q,
    input logic [NUM_PHYS-1:0]        free_map,
    input logic                       alloc_valid,
    input logic [EW-1:0]              alloc_idx,
    input logic [EW-1:0]              wb_idx,
    input logic                       wb_stall,
    input logic                       wb_phys_valid,
    input logic [PW-1:0]              wb_phys_prn,
    input logic                       wb_copy,
    input logic                       cm_valid,
    input logic [EW-1:0]              cm_idx,
    input logic [EW-1:0]              cm_old_idx,
    input logic                       cm_move_valid,
    input logic [PW-1:0]              cm_move_prn
);
    int phys_cnt;
    always_comb begin
        phys_cnt = 0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (st[i] == 2'd2) phys_cnt++;
        end
    end

    p_alloc_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid |=> st[$past(alloc_idx)] == 2'd1);

    p_grant_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_phys_valid |-> free_map[wb_phys_prn]);

    p_wb_phys_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_phys_valid |=> st[$past(wb_idx)] == 2'd2 &&
                          prn_q[$past(wb_idx)] == $past(wb_phys_prn));

    p_stall_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stall |-> free_map == '0 && !wb_phys_valid);

    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stall |=> st[$past(wb_idx)] == $past(st[wb_idx]));

    p_copy_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_copy |-> wb_phys_valid);

    p_commit_log_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && cm_idx != cm_old_idx) |=> st[$past(cm_idx)] == 2'd3);

    p_move_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cm_move_valid |=> free_map[$past(cm_move_prn)]);

    p_pool_balance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(free_map) + phys_cnt == NUM_PHYS);

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && cm_idx != cm_old_idx) |=> st[$past(cm_old_idx)] == 2'd0);
endmodule

bind xrt_table xrt_checker #(.NUM_ENT(NUM_ENT), .NUM_PHYS(NUM_PHYS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st           (st),
    .prn_q        (prn_q),
    .free_map     (free_map),
    .alloc_valid  (alloc_valid),
    .alloc_idx    (alloc_idx),
    .wb_idx       (wb_idx),
    .wb_stall     (wb_stall),
    .wb_phys_valid(wb_phys_valid),
    .wb_phys_prn  (wb_phys_prn),
    .wb_copy      (wb_copy),
    .cm_valid     (cm_valid),
    .cm_idx       (cm_idx),
    .cm_old_idx   (cm_old_idx),
    .cm_move_valid(cm_move_valid),
    .cm_move_prn  (cm_move_prn)
);

// File: tb/tb_xrt_table.sv
module tb_xrt_table;
    localparam int NL = 4;
    localparam int NE = 8;
    localparam int NP = 2;
    localparam int EW = $clog2(NE);
    localparam int LW = $clog2(NL);
    localparam int PW = $clog2(NP);
    localparam int AW = (LW > PW) ? LW : PW;
    localparam int ITER = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid, wb_valid, wb_cancel, cm_valid;
    logic [EW-1:0] alloc_idx, wb_idx, wb_old_idx, cm_idx, cm_old_idx, rd_idx;
    logic [LW-1:0] rd_lreg;
    logic wb_stall, wb_phys_valid, wb_copy, cm_move_valid, rd_ready, rd_phys;
    logic [PW-1:0] wb_phys_prn, wb_copy_src, cm_move_prn;
    logic [AW-1:0] rd_addr;

    always #2 clk = ~clk;

    xrt_table #(.NUM_LOG(NL), .NUM_ENT(NE), .NUM_PHYS(NP)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_cancel(wb_cancel),
        .wb_old_idx(wb_old_idx), .wb_stall(wb_stall),
        .wb_phys_valid(wb_phys_valid), .wb_phys_prn(wb_phys_prn),
        .wb_copy(wb_copy), .wb_copy_src(wb_copy_src),
        .cm_valid(cm_valid), .cm_idx(cm_idx), .cm_old_idx(cm_old_idx),
        .cm_move_valid(cm_move_valid), .cm_move_prn(cm_move_prn),
        .rd_idx(rd_idx), .rd_lreg(rd_lreg), .rd_ready(rd_ready),
        .rd_phys(rd_phys), .rd_addr(rd_addr)
    );

    // model: 0 free, 1 wait, 2 phys, 3 log
    int    m_st  [NE];
    int    m_prn [NE];
    bit    m_free[NP];
    string m_tag [NE];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int p = 0; p < NP; p++) if (m_free[p]) return p;
        return -1;
    endfunction

    task automatic clear_inputs();
        alloc_valid = 1'b0; alloc_idx = '0;
        wb_valid = 1'b0; wb_cancel = 1'b0; wb_idx = '0; wb_old_idx = '0;
        cm_valid = 1'b0; cm_idx = '0; cm_old_idx = '0;
    endtask

    task automatic check_read(input int e, input int lr);
        string t;
        int er, ep, ea;
        t  = $sformatf("R10 entry %0d via %s", e, m_tag[e]);
        er = (m_st[e] >= 2) ? 1 : 0;
        ep = (m_st[e] == 2) ? 1 : 0;
        ea = ep ? m_prn[e] : lr;
        chk({t, " ready"}, int'(rd_ready), er);
        chk({t, " phys"},  int'(rd_phys), ep);
        chk({t, " addr"},  int'(rd_addr), ea);
    endtask

    initial begin
        clear_inputs();
        rd_idx = '0; rd_lreg = '0;
        for (int e = 0; e < NE; e++) begin
            m_st[e] = (e < NL) ? 3 : 0; m_prn[e] = 0; m_tag[e] = "R1";
        end
        for (int p = 0; p < NP; p++) m_free[p] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state through the read port
        for (int e = 0; e < NE; e++) begin
            @(negedge clk);
            rd_idx = EW'(e); rd_lreg = LW'(e % NL);
            #1;
            check_read(e, e % NL);
        end

        for (int it = 0; it < ITER; it++) begin
            int op, e, old, lf, ewb, ep, ec, es, em, emp, r;
            @(negedge clk);
            clear_inputs();
            seed = seed * 32'd1103515245 + 32'd12345;
            op = int'(seed[17:16]);
            r  = int'(seed[26:24]);
            e  = -1;
            old = -1;
            ewb = 0; ep = 0; ec = 0; es = 0; em = 0; emp = 0;
            rd_idx  = EW'(it % NE);
            rd_lreg = LW'((it / NE) % NL);
            #0;
            if (op == 0) begin
                for (int k = 0; k < NE; k++)
                    if (e < 0 && m_st[(r + k) % NE] == 0) e = (r + k) % NE;
                if (e >= 0) begin
                    alloc_valid = 1'b1; alloc_idx = EW'(e);
                end
            end else if (op == 1) begin
                for (int k = 0; k < NE; k++)
                    if (e < 0 && m_st[(r + k) % NE] == 1) e = (r + k) % NE;
                if (e >= 0) begin
                    old = int'(seed[30:28]) % NE;
                    if (old == e) old = (old + 1) % NE;
                    wb_valid = 1'b1; wb_idx = EW'(e); wb_old_idx = EW'(old);
                    wb_cancel = seed[20];
                end
            end else if (op == 2) begin
                for (int k = 0; k < NE; k++)
                    if (e < 0 && m_st[(r + k) % NE] != 0) e = (r + k) % NE;
                if (e >= 0) begin
                    for (int k = 1; k < NE; k++)
                        if (old < 0 && m_st[(e + int'(seed[30:28]) + k) % NE] != 2 &&
                            (e + int'(seed[30:28]) + k) % NE != e)
                            old = (e + int'(seed[30:28]) + k) % NE;
                    if (old >= 0) begin
                        cm_valid = 1'b1; cm_idx = EW'(e); cm_old_idx = EW'(old);
                    end else e = -1;
                end
            end
            #1;
            check_read(it % NE, (it / NE) % NL);

            if (op == 1 && e >= 0) begin
                lf = lowest_free();
                if (!wb_cancel || m_st[old] == 2) begin
                    if (lf < 0) begin
                        es = 1;
                        chk(wb_cancel ? "R4 stall on copy" : "R4 stall", int'(wb_stall), 1);
                        chk("R4 no grant", int'(wb_phys_valid), 0);
                    end else begin
                        ewb = 1; ep = lf;
                        ec = wb_cancel ? 1 : 0;
                        chk(wb_cancel ? "R5 grant" : "R3 grant", int'(wb_phys_valid), 1);
                        chk(wb_cancel ? "R5 prn" : "R3 lowest prn", int'(wb_phys_prn), lf);
                        chk("R5 copy flag", int'(wb_copy), ec);
                        if (ec == 1) chk("R5 copy source", int'(wb_copy_src), m_prn[old]);
                        chk("R3 no stall", int'(wb_stall), 0);
                    end
                end else begin
                    chk(m_st[old] == 3 ? "R6 no grant" : "R7 no grant", int'(wb_phys_valid), 0);
                    chk("R7 no stall", int'(wb_stall), 0);
                    chk("R7 no copy", int'(wb_copy), 0);
                end
            end else begin
                chk("R3 idle grant", int'(wb_phys_valid), 0);
                chk("R4 idle stall", int'(wb_stall), 0);
            end

            if (op == 2 && e >= 0 && m_st[e] == 2) begin
                em = 1; emp = m_prn[e];
            end
            chk("R8 move valid", int'(cm_move_valid), em);
            if (em == 1) chk("R8 move prn", int'(cm_move_prn), emp);

            // model update
            if (op == 0 && e >= 0) begin
                m_st[e] = 1; m_tag[e] = "R2";
            end else if (op == 1 && e >= 0) begin
                if (ewb == 1) begin
                    m_st[e] = 2; m_prn[e] = ep; m_free[ep] = 1'b0;
                    m_tag[e] = (ec == 1) ? "R5" : "R3";
                end else if (es == 0 && wb_cancel && m_st[old] == 3) begin
                    m_st[e] = 3; m_tag[e] = "R6";
                end else if (es == 1) begin
                    m_tag[e] = "R4";
                end else begin
                    m_tag[e] = "R7";
                end
            end else if (op == 2 && e >= 0) begin
                if (m_st[e] == 2) begin
                    m_free[m_prn[e]] = 1'b1; m_tag[e] = "R8";
                end else if (m_st[e] == 1) begin
                    m_tag[e] = "R7";
                end
                m_st[e] = 3;
                m_st[old] = 0; m_tag[old] = "R9";
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule